// File: doc/BRIEF.md
# Frame Symbol Serializer for a 2.4 GHz Low-Rate Radio

This block turns a MAC frame held in a byte-wide transmit buffer into an ordered stream of 4-bit symbols. The symbols go on to a spreading and modulation stage, which is not part of this block. On a start request it sends a run of all-zero preamble bytes whose count is set by a register. It then sends a frame delimiter byte taken from a sync register. It pulls a length byte and then the payload bytes out of the buffer. Last, it appends a 16-bit frame check sequence that it computes itself over the payload.

The buffer behaves like a show-ahead FIFO: `bufData` shows the oldest byte whenever `bufAvail` is high, and the block removes that byte with a one-cycle `bufPop`. The first buffer byte is the frame length, and that length counts the two check bytes. Symbols leave under a valid/ready handshake, and each byte goes out as two symbols, low nibble first. The block raises a pulse once the delimiter has fully left and a pulse when the frame is done. If the buffer cannot supply a byte that the length promised, the frame is abandoned and a sticky underflow flag is raised.

Top module: `phy_frame_tx`

## Requirements
- R1: When idle, a high `startReq` at a clock edge begins a frame, and `symValid` is high from the next cycle. A `startReq` seen while a frame is in progress is ignored and leaves the symbol stream unchanged.
- R2: The frame opens with `preambleCode`+1 bytes of 0x00. The code is 4 bits, so the preamble is 1 to 16 bytes long.
- R3: After the preamble comes one delimiter byte equal to `syncWord[15:8]`.
- R4: The next byte is the first byte popped from the buffer, sent with bit 7 forced to 0. Bits 6:0 give the frame length L. If L is below 2, no payload bytes follow.
- R5: After the length byte, L-2 payload bytes are popped and sent in buffer order. `bufPop` is only high while `bufAvail` is high. No byte beyond the frame is popped.
- R6: Every byte is sent as two symbols on `symData`: bits 3:0 first, then bits 7:4.
- R7: The payload is followed by a check value computed over the payload bytes only. The register starts at 0 and uses generator x^16+x^12+x^5+1 in reflected form (0x8408), with each byte entering LSB first. Bits 7:0 of the check value are sent first, then bits 15:8. The nine ASCII bytes "123456789" give 0x2189.
- R8: While `symValid` is high and `symReady` is low, `symValid` stays high and `symData` does not change on the next cycle.
- R9: `sfdSent` is high for exactly one cycle: the cycle after the handshake of the delimiter's second symbol.
- R10: `frameDone` is high for exactly one cycle: the cycle after the handshake of the last check symbol. In that cycle `symValid` is already low.
- R11: If a length or payload byte is needed while `bufAvail` is low, the frame ends at that byte boundary without `frameDone`. `underflow` then rises and stays high until the next accepted start clears it.
- R12: After reset, `symValid`, `bufPop`, `sfdSent`, `frameDone` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to send one frame |
| preambleCode | input | 4 | Preamble byte count minus one |
| syncWord | input | 16 | Sync register; bits 15:8 are the delimiter byte |
| bufAvail | input | 1 | Buffer holds at least one byte |
| bufData | input | 8 | Oldest buffer byte (show-ahead) |
| bufPop | output | 1 | Removes the oldest buffer byte |
| symData | output | 4 | Outgoing symbol |
| symValid | output | 1 | Symbol on `symData` is valid |
| symReady | input | 1 | Downstream accepts the symbol |
| sfdSent | output | 1 | One-cycle pulse after the delimiter has left |
| frameDone | output | 1 | One-cycle pulse after the last check symbol |
| underflow | output | 1 | Sticky: buffer ran dry inside a frame |

## Verification
The assertions check the local rules on every cycle:
- a symbol is held steady while the receiver is not ready;
- nothing is popped from an empty buffer;
- the frame is idle by the time the done pulse shows;
- a rising underflow coincides with the end of the frame;
- the two pulses never coincide.

Only the bench scenarios can show that the symbols come out in the right order with the right values, and that the check value is correct. The same goes for the pulse timing against the handshake of a particular symbol and for the exact number of bytes popped. The scenarios are needed as well to show that a mid-frame start changes nothing and that the underflow flag clears on the next start. For this the bench uses several preamble lengths, delimiter values, short and stalled frames, and buffers that run dry at the length byte and in mid-payload.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = BYTE_W / 2;
  localparam int LEN_W  = BYTE_W - 1;
  localparam int CRC_W  = 16;
  localparam int SYNC_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_LEN, ST_PAY, ST_FCS_LO, ST_FCS_HI
  } txState_t;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_SYNC, SRC_LEN, SRC_PAY, SRC_CRC_LO, SRC_CRC_HI
  } byteSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;      // capture a new current byte
    byteSrc_t src;       // where the new byte comes from
    logic     hiNib;     // symbol select: 0 low nibble, 1 high nibble
    logic     crcClear;  // restart the check register
  } dpCtrl_t;
endpackage

// File: rtl/tx_crc_step.sv
module tx_crc_step #(
  parameter int CRC_W  = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);
  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crcIn;

  // one reflected shift per data bit, LSB of the byte first
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb = stage[g][0] ^ dataIn[g];
    assign stage[g+1] = (stage[g] >> 1) ^ ({CRC_W{fb}} & POLY);
  end

  assign crcOut = stage[DATA_W];
endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpCtrl_t             dp,
  input  logic [SYNC_W-1:0]   syncWord,
  input  logic [BYTE_W-1:0]   bufData,
  output logic [SYM_W-1:0]    symData
);
  logic [BYTE_W-1:0] curByte;
  logic [BYTE_W-1:0] nextByte;
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcNext;

  tx_crc_step #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(CRC_POLY)) u_step (
    .crcIn (crcReg),
    .dataIn(bufData),
    .crcOut(crcNext)
  );

  always_comb begin
    unique case (dp.src)
      SRC_SYNC:   nextByte = syncWord[SYNC_W-1 -: BYTE_W];
      SRC_LEN:    nextByte = {1'b0, bufData[LEN_W-1:0]};
      SRC_PAY:    nextByte = bufData;
      SRC_CRC_LO: nextByte = crcReg[BYTE_W-1:0];
      SRC_CRC_HI: nextByte = crcReg[CRC_W-1 -: BYTE_W];
      default:    nextByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curByte <= '0;
      crcReg  <= '0;
    end else begin
      if (dp.load) curByte <= nextByte;
      if (dp.crcClear) crcReg <= '0;
      else if (dp.load && dp.src == SRC_PAY) crcReg <= crcNext;
    end
  end

  assign symData = dp.hiNib ? curByte[BYTE_W-1 -: SYM_W] : curByte[SYM_W-1:0];

  // R7: the check register only moves while payload is being loaded
  a_r7_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (dp.load && (dp.src == SRC_CRC_LO)) |=> $stable(crcReg));
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [PRE_W-1:0] preambleCode,
  input  logic             bufAvail,
  input  logic [LEN_W-1:0] lenField,
  input  logic             symReady,
  output dpCtrl_t          dp,
  output logic             symValid,
  output logic             bufPop,
  output logic             sfdSent,
  output logic             frameDone,
  output logic             underflow
);
  txState_t         state, stateNext;
  logic             hiNib;
  logic [PRE_W-1:0] preCnt, preNext;
  logic [LEN_W-1:0] payCnt, payNext;
  logic             fire, byteEnd, accept;
  logic             load, crcClear, popEv, uflowEv, sfdEv, doneEv;
  byteSrc_t         src;

  assign symValid = (state != ST_IDLE);
  assign fire     = symValid & symReady;
  assign byteEnd  = fire & hiNib;
  assign accept   = (state == ST_IDLE) & startReq;

  always_comb begin
    stateNext = state;
    preNext   = preCnt;
    payNext   = payCnt;
    load      = 1'b0;
    src       = SRC_ZERO;
    crcClear  = 1'b0;
    popEv     = 1'b0;
    uflowEv   = 1'b0;
    sfdEv     = 1'b0;
    doneEv    = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stateNext = ST_PRE;
        load      = 1'b1;
        crcClear  = 1'b1;
        preNext   = preambleCode;
      end
      ST_PRE: if (byteEnd) begin
        load = 1'b1;
        if (preCnt == '0) begin
          stateNext = ST_SFD;
          src       = SRC_SYNC;
        end else begin
          preNext = preCnt - PRE_W'(1);
        end
      end
      ST_SFD: if (byteEnd) begin
        sfdEv = 1'b1;
        if (bufAvail) begin
          stateNext = ST_LEN;
          load      = 1'b1;
          src       = SRC_LEN;
          popEv     = 1'b1;
          payNext   = (lenField < LEN_W'(2)) ? '0 : lenField - LEN_W'(2);
        end else begin
          stateNext = ST_IDLE;
          uflowEv   = 1'b1;
        end
      end
      ST_LEN, ST_PAY: if (byteEnd) begin
        if (payCnt == '0) begin
          stateNext = ST_FCS_LO;
          load      = 1'b1;
          src       = SRC_CRC_LO;
        end else if (bufAvail) begin
          stateNext = ST_PAY;
          load      = 1'b1;
          src       = SRC_PAY;
          popEv     = 1'b1;
          payNext   = payCnt - LEN_W'(1);
        end else begin
          stateNext = ST_IDLE;
          uflowEv   = 1'b1;
        end
      end
      ST_FCS_LO: if (byteEnd) begin
        stateNext = ST_FCS_HI;
        load      = 1'b1;
        src       = SRC_CRC_HI;
      end
      ST_FCS_HI: if (byteEnd) begin
        stateNext = ST_IDLE;
        doneEv    = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hiNib     <= 1'b0;
      preCnt    <= '0;
      payCnt    <= '0;
      sfdSent   <= 1'b0;
      frameDone <= 1'b0;
      underflow <= 1'b0;
    end else begin
      state     <= stateNext;
      preCnt    <= preNext;
      payCnt    <= payNext;
      if (fire) hiNib <= ~hiNib;
      sfdSent   <= sfdEv;
      frameDone <= doneEv;
      if (accept) underflow <= 1'b0;
      else if (uflowEv) underflow <= 1'b1;
    end
  end

  assign bufPop = popEv;
  assign dp     = '{load: load, src: src, hiNib: hiNib, crcClear: crcClear};

  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    bufPop |-> bufAvail);
  a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (symValid && !symReady) |=> symValid);
  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> !symValid);
  a_r11_uflow_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> (!symValid && !frameDone));
  a_r9_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfdSent && frameDone));
  a_r1_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (symValid && !fire) |=> (symValid && $stable(hiNib)));
endmodule

// File: rtl/phy_frame_tx.sv
module phy_frame_tx
  import tx_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [PRE_W-1:0]  preambleCode,
  input  logic [SYNC_W-1:0] syncWord,
  input  logic              bufAvail,
  input  logic [BYTE_W-1:0] bufData,
  output logic              bufPop,
  output logic [SYM_W-1:0]  symData,
  output logic              symValid,
  input  logic              symReady,
  output logic              sfdSent,
  output logic              frameDone,
  output logic              underflow
);
  dpCtrl_t dp;

  tx_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .startReq    (startReq),
    .preambleCode(preambleCode),
    .bufAvail    (bufAvail),
    .lenField    (bufData[LEN_W-1:0]),
    .symReady    (symReady),
    .dp          (dp),
    .symValid    (symValid),
    .bufPop      (bufPop),
    .sfdSent     (sfdSent),
    .frameDone   (frameDone),
    .underflow   (underflow)
  );

  tx_datapath #(.CRC_POLY(CRC_POLY)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .dp      (dp),
    .syncWord(syncWord),
    .bufData (bufData),
    .symData (symData)
  );

  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (symValid && !symReady) |=> $stable(symData));
endmodule

// File: tb/sim_phy_frame_tx.sv
`timescale 1ns/1ps
module sim_phy_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startReq = 1'b0;
  logic [3:0]  preambleCode = '0;
  logic [15:0] syncWord = 16'hA700;
  logic        bufAvail;
  logic [7:0]  bufData;
  logic        bufPop;
  logic [3:0]  symData;
  logic        symValid;
  logic        symReady = 1'b1;
  logic        sfdSent, frameDone, underflow;

  always #10 clk = ~clk;

  phy_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .preambleCode(preambleCode),
    .syncWord(syncWord), .bufAvail(bufAvail), .bufData(bufData), .bufPop(bufPop),
    .symData(symData), .symValid(symValid), .symReady(symReady),
    .sfdSent(sfdSent), .frameDone(frameDone), .underflow(underflow)
  );

  // buffer model: show-ahead byte store
  logic [7:0] mem [0:255];
  int rdPtr = 0;
  int wrPtr = 0;
  assign bufAvail = (rdPtr < wrPtr);
  assign bufData  = mem[rdPtr[7:0]];
  always @(posedge clk) if (bufPop && rst_n) rdPtr <= rdPtr + 1;

  // ready pattern
  int readyMode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    case (readyMode)
      1: symReady = (cyc % 3) != 0;
      2: symReady = (cyc % 5) < 2;
      default: symReady = 1'b1;
    endcase
  end

  int nChecks = 0;
  int nFail = 0;
  task automatic chk(input bit ok, input int r, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL R%0d actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // reference model state
  int expV[$];
  int expR[$];
  int symIdx = 0;
  int sfdIdx = -1;
  bit expDone = 0;
  bit pendSfd = 0;
  bit pendDone = 0;
  int doneSeen = 0;
  bit monOn = 0;

  always @(negedge clk) if (monOn) begin
    if (sfdSent || pendSfd) chk(sfdSent == pendSfd, 9, sfdSent, pendSfd);       // R9
    if (frameDone || pendDone) chk(frameDone == pendDone, 10, frameDone, pendDone); // R10
    if (frameDone) doneSeen++;
    pendSfd = 0;
    pendDone = 0;
    if (symValid && symReady) begin
      if (expV.size() == 0) chk(0, 1, symData, -1); // R1: no symbol expected
      else begin
        int v, r;
        v = expV.pop_front();
        r = expR.pop_front();
        chk(symData == v[3:0], r, symData, v);
        if (symIdx == sfdIdx) pendSfd = 1;
        if (expV.size() == 0 && expDone) pendDone = 1;
        symIdx++;
      end
    end
  end

  // check value in MSB-first form on bit-reversed input, then reflected
  function automatic logic [15:0] crcRef(input int first, input int n);
    logic [15:0] c = '0;
    logic [15:0] o;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[15] ^ mem[(first + k) % 256][i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    for (int i = 0; i < 16; i++) o[i] = c[15 - i];
    return o;
  endfunction

  task automatic pushByte(input int b);
    mem[wrPtr % 256] = b[7:0];
    wrPtr++;
  endtask

  task automatic pushSym(input int b, input int r);
    expV.push_back(b & 15);        expR.push_back(r);
    expV.push_back((b >> 4) & 15); expR.push_back(r);   // R6: low nibble first
  endtask

  task automatic runFrame(input int code, input int sw, input int rmode, input bit midStart);
    int avail, len, n, have, pops, startRd, guard;
    bit uf;
    logic [15:0] crc;
    expV.delete(); expR.delete();
    symIdx = 0;
    doneSeen = 0;
    for (int i = 0; i < code + 1; i++) pushSym(0, 2);   // R2
    pushSym((sw >> 8) & 255, 3);                         // R3
    sfdIdx = 2 * (code + 1) + 1;
    startRd = rdPtr;
    avail = wrPtr - rdPtr;
    uf = 0; pops = 0; expDone = 0;
    if (avail == 0) uf = 1;
    else begin
      len = mem[rdPtr % 256] & 8'h7F;
      pushSym(len, 4);                                   // R4
      n = (len < 2) ? 0 : len - 2;
      have = avail - 1;
      if (have < n) begin
        for (int k = 0; k < have; k++) pushSym(mem[(rdPtr + 1 + k) % 256], 5); // R5
        uf = 1; pops = 1 + have;
      end else begin
        for (int k = 0; k < n; k++) pushSym(mem[(rdPtr + 1 + k) % 256], 5);    // R5
        crc = crcRef(rdPtr + 1, n);
        pushSym(crc[7:0], 7);                            // R7
        pushSym(crc[15:8], 7);
        pops = 1 + n; expDone = 1;
      end
    end
    @(posedge clk); #2;
    preambleCode = code[3:0];
    syncWord = sw[15:0];
    readyMode = rmode;
    startReq = 1;
    @(posedge clk); #2;
    startReq = 0;
    chk(symValid == 1, 1, symValid, 1);                  // R1
    chk(underflow == 0, 11, underflow, 0);               // R11 cleared on start
    if (midStart) begin
      repeat (5) @(posedge clk);
      #2 startReq = 1;
      @(posedge clk); #2 startReq = 0;
    end
    guard = 0;
    while (1) begin
      @(negedge clk);
      if (!symValid) break;
      guard++;
      if (guard > 5000) begin chk(0, 10, guard, 0); break; end
    end
    @(posedge clk); #2;
    chk(expV.size() == 0, uf ? 11 : 7, expV.size(), 0);
    chk(underflow == uf, 11, underflow, uf);             // R11
    chk(rdPtr - startRd == pops, 5, rdPtr - startRd, pops); // R5
    chk(doneSeen == int'(expDone), 10, doneSeen, expDone);  // R10
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R12: reset state
    chk(symValid == 0, 12, symValid, 0);
    chk(bufPop == 0, 12, bufPop, 0);
    chk(sfdSent == 0 && frameDone == 0, 12, {sfdSent, frameDone}, 0);
    chk(underflow == 0, 12, underflow, 0);
    rst_n = 1;
    monOn = 1;
    // R7: known vector of the check function
    for (int i = 0; i < 9; i++) pushByte(8'h31 + i);
    rdPtr = 9;
    chk(crcRef(0, 9) == 16'h2189, 7, crcRef(0, 9), 16'h2189);
    rdPtr = 0; wrPtr = 0;
    @(posedge clk);

    // standard 3-byte preamble, 9 payload bytes
    pushByte(8'h0B);
    for (int i = 0; i < 9; i++) pushByte(8'h31 + i);
    runFrame(2, 16'hA700, 0, 0);

    // 1-byte preamble, other delimiter, bit 7 of length set, stalls, spare byte
    pushByte(8'h85); pushByte(8'hF0); pushByte(8'h0F); pushByte(8'hC3);
    pushByte(8'h01);
    runFrame(0, 16'h3CC1, 1, 0);

    // spare byte is length 1: no payload; 16-byte preamble; mid-frame start (R1)
    runFrame(15, 16'hA7FF, 2, 1);

    // underflow mid-payload
    pushByte(8'h0A); pushByte(8'h11); pushByte(8'h22); pushByte(8'h33);
    runFrame(1, 16'hA700, 0, 0);
    repeat (4) @(posedge clk);
    #2 chk(underflow == 1, 11, underflow, 1);            // R11 held

    // underflow at the length byte
    runFrame(0, 16'h5500, 1, 0);

    // normal frame clears flag
    pushByte(8'h04); pushByte(8'hDE); pushByte(8'hAD);
    runFrame(3, 16'hA700, 2, 0);

    // length exactly 2: check bytes only
    pushByte(8'h02);
    runFrame(2, 16'hA700, 1, 1);

    repeat (3) @(posedge clk);
    #2 chk(symValid == 0 && frameDone == 0, 10, symValid, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule